// File: doc/BRIEF.md
# Interrupt CALL Injector

This block collects interrupt requests from up to eight sources and presents one request line to an 8080-style processor. When the processor acknowledges, the block answers the acknowledge read cycles with a complete three-byte subroutine call. The first byte is the CALL opcode 0xCD. The second and third bytes are the low and high bytes of a vector address that belongs to the winning source. While acknowledge is high the processor does not advance its program counter, so the block keeps its own byte counter and has no address input.

The processor bus is a plain synchronous interface. A read is qualified in a cycle where the bus-valid enable and the read strobe are both high and the IO flag is low. The block registers its answer, and the byte is on `data_out` during the following cycle, ready for capture on the next rising edge. The bus valid enable acts as the data-valid qualifier. The block can never apply back-pressure: every qualified read gets a byte in the next cycle. Requests, acknowledge and the request output are plain level control pins.

Top module: `irq_call_injector`

## Requirements
- R1: A high level on bit n of `src_req` in a cycle latches request n at the next rising edge. The request stays latched after the input falls.
- R2: `irq_out` is high when at least one request is latched and no acknowledge sequence is active. It is low in every cycle in which `cpu_ack` is high. After `cpu_ack` falls it goes high again one cycle later if a request is still latched.
- R3: During an acknowledge sequence, successive qualified reads return 0xCD, then the vector low byte, then the vector high byte. Each byte appears on `data_out` in the cycle after its read.
- R4: The vector address for source n is 8 × n (source 0 → 0x0000, source 3 → 0x0018, source 7 → 0x0038).
- R5: The lowest-numbered latched request wins. The choice is frozen in the first cycle that `cpu_ack` is high, and requests latched later do not change the vector bytes of that sequence.
- R6: After the third byte is read, the serviced request is cleared and every other latched request stays latched.
- R7: A qualified read while `cpu_ack` is low returns 0x00 and does not advance the byte sequence.
- R8: A read with `bus_io` high returns 0x00 and does not advance the byte sequence.
- R9: If `cpu_ack` falls before the third byte is read, the byte counter restarts and the request stays latched, so it is offered again from the opcode.
- R10: A one-cycle `rst` pulse clears all latched requests, the byte counter and `data_out`.
- R11: If no request is latched when `cpu_ack` rises, the reads of that sequence return 0x00. Reads after the third byte of a sequence also return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all transfers on the rising edge |
| rst | input | 1 | Synchronous reset pulse, active high |
| src_req | input | 8 | Interrupt request inputs, one per source |
| cpu_ack | input | 1 | Interrupt acknowledge from the processor |
| bus_valid | input | 1 | Processor bus-valid enable |
| bus_rd | input | 1 | Processor read strobe |
| bus_io | input | 1 | Processor IO flag; high marks an IO access |
| data_out | output | 8 | Byte for the processor data input, valid the cycle after a read |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A byte counter that has slipped shows up at once as a misplaced 0xCD or vector byte on the read that follows. A wrong frozen source shows up as a vector byte that belongs to another source. A request bit that is left set or wrongly cleared shows at `irq_out` one cycle after `cpu_ack` falls, and at the vector of the next sequence. The scoreboard compares every byte returned one cycle after its read, so a fault is found within two clocks of the read that exposes it.

// File: rtl/irq_inj_pkg.sv
package irq_inj_pkg;
  localparam logic [7:0] CALL_OPCODE = 8'hCD;

  typedef enum logic [1:0] {
    PH_OP   = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  function automatic logic [15:0] vec_addr(input int unsigned idx, input int unsigned stride);
    return 16'(idx * stride);
  endfunction
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NUM_SRC = 8,
  localparam int IW = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_en,
  input  logic [IW-1:0]      clr_idx,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] clr_mask;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_mask[i] = clr_en && (clr_idx == IW'(i));
  end

  // a new request in the same cycle wins over the clear
  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= (pend_o & ~clr_mask) | set_i;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC = 8,
  localparam int IW = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [IW-1:0]      idx_o,
  output logic               any_o
);
  logic [NUM_SRC:0]   seen;
  logic [NUM_SRC-1:0] hit;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign hit[i]    = pend_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | pend_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hit[i]) idx_o = IW'(i);
    end
  end

  assign any_o = seen[NUM_SRC];
endmodule

// File: rtl/irq_byte_seq.sv
module irq_byte_seq
  import irq_inj_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int VEC_STRIDE = 8,
  localparam int IW = $clog2(NUM_SRC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_i,
  input  logic          qrd_i,
  input  logic [IW-1:0] pick_idx_i,
  input  logic          pick_any_i,
  output logic [7:0]    data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [IW-1:0] done_idx_o
);
  phase_e        phase;
  phase_e        phase_nxt;
  logic [IW-1:0] sel_q;
  logic          sel_v_q;
  logic [IW-1:0] cur_idx;
  logic          cur_v;
  logic [15:0]   vec;
  logic [7:0]    byte_nxt;
  logic          take;

  // the first acknowledge cycle uses the live pick, later ones the frozen copy
  assign cur_idx = busy_o ? sel_q   : pick_idx_i;
  assign cur_v   = busy_o ? sel_v_q : pick_any_i;
  assign vec     = vec_addr(cur_idx, VEC_STRIDE);
  assign take    = ack_i & qrd_i;

  always_comb begin
    byte_nxt  = 8'h00;
    phase_nxt = phase;
    unique case (phase)
      PH_OP: begin
        byte_nxt  = cur_v ? CALL_OPCODE : 8'h00;
        phase_nxt = cur_v ? PH_LO : PH_DONE;
      end
      PH_LO: begin
        byte_nxt  = vec[7:0];
        phase_nxt = PH_HI;
      end
      PH_HI: begin
        byte_nxt  = vec[15:8];
        phase_nxt = PH_DONE;
      end
      default: begin
        byte_nxt  = 8'h00;
        phase_nxt = PH_DONE;
      end
    endcase
  end

  assign done_o     = take && (phase == PH_HI);
  assign done_idx_o = cur_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= 8'h00;
      busy_o  <= 1'b0;
      phase   <= PH_OP;
      sel_q   <= '0;
      sel_v_q <= 1'b0;
    end else begin
      data_o <= take ? byte_nxt : 8'h00;
      if (!ack_i) begin
        busy_o <= 1'b0;
        phase  <= PH_OP;
      end else begin
        busy_o <= 1'b1;
        if (!busy_o) begin
          sel_q   <= pick_idx_i;
          sel_v_q <= pick_any_i;
        end
        if (qrd_i) phase <= phase_nxt;
      end
    end
  end
endmodule

// File: rtl/irq_call_injector.sv
module irq_call_injector #(
  parameter int NUM_SRC    = 8,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               cpu_ack,
  input  logic               bus_valid,
  input  logic               bus_rd,
  input  logic               bus_io,
  output logic [7:0]         data_out,
  output logic               irq_out
);
  localparam int IW = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pend;
  logic [IW-1:0]      pick_idx;
  logic               pick_any;
  logic               qrd;
  logic               busy;
  logic               done;
  logic [IW-1:0]      done_idx;

  assign qrd = bus_valid & bus_rd & ~bus_io;

  irq_req_latch #(.NUM_SRC(NUM_SRC)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .set_i   (src_req),
    .clr_en  (done),
    .clr_idx (done_idx),
    .pend_o  (pend)
  );

  irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend_i (pend),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  irq_byte_seq #(.NUM_SRC(NUM_SRC), .VEC_STRIDE(VEC_STRIDE)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ack_i      (cpu_ack),
    .qrd_i      (qrd),
    .pick_idx_i (pick_idx),
    .pick_any_i (pick_any),
    .data_o     (data_out),
    .busy_o     (busy),
    .done_o     (done),
    .done_idx_o (done_idx)
  );

  assign irq_out = pick_any & ~cpu_ack & ~busy;
endmodule

// File: rtl/irq_call_injector_chk.sv
module irq_call_injector_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_req,
  input logic               cpu_ack,
  input logic               bus_valid,
  input logic               bus_rd,
  input logic               bus_io,
  input logic [7:0]         data_out,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] pend,
  input logic               busy
);
  assert_irq_low_in_ack_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |-> !irq_out);

  assert_no_ack_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_rd && !cpu_ack) |=> (data_out == 8'h00));

  assert_io_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_io) |=> (data_out == 8'h00));

  assert_latch_holds_R1: assert property (@(posedge clk) disable iff (rst)
    (src_req != '0) |=> ((pend & $past(src_req)) == $past(src_req)));

  assert_opcode_first_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && !busy && bus_valid && bus_rd && !bus_io && (pend != '0))
      |=> (data_out == 8'hCD));

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> ((pend == '0) && (data_out == 8'h00)));
endmodule

bind irq_call_injector irq_call_injector_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_req   (src_req),
  .cpu_ack   (cpu_ack),
  .bus_valid (bus_valid),
  .bus_rd    (bus_rd),
  .bus_io    (bus_io),
  .data_out  (data_out),
  .irq_out   (irq_out),
  .pend      (pend),
  .busy      (busy)
);

// File: tb/irq_call_injector_bench.sv
module irq_call_injector_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] src_req = '0;
  logic       cpu_ack = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_io = 1'b0;
  logic [7:0] data_out;
  logic       irq_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] b;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  logic read_seen = 1'b0;

  always #10 clk = ~clk;

  irq_call_injector u_irq_call_injector (
    .clk(clk), .rst(rst), .src_req(src_req), .cpu_ack(cpu_ack),
    .bus_valid(bus_valid), .bus_rd(bus_rd), .bus_io(bus_io),
    .data_out(data_out), .irq_out(irq_out)
  );

  function automatic logic [15:0] vec_of(input int n);
    return 16'(n * 8);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: any read seen at a rising edge is answered in the following cycle
  always @(posedge clk) read_seen <= bus_valid & bus_rd;

  always @(negedge clk) begin
    if (read_seen) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard empty", data_out, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(data_out == e.b, e.tag, data_out, e.b);
      end
    end
  end

  task automatic pulse_src(input logic [7:0] mask);
    @(negedge clk); src_req = mask;
    @(negedge clk); src_req = '0;
  endtask

  task automatic set_ack(input logic v);
    @(negedge clk); cpu_ack = v;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag, input logic io = 1'b0);
    exp_t e;
    e.b = exp; e.tag = tag;
    @(negedge clk);
    bus_valid = 1'b1; bus_rd = 1'b1; bus_io = io;
    exp_q.push_back(e);
    @(negedge clk);
    bus_valid = 1'b0; bus_rd = 1'b0; bus_io = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk); #1;
    check(irq_out == exp, tag, irq_out, exp);
  endtask

  task automatic full_call(input int n, input string tag);
    rd(8'hCD, {tag, " opcode R3"});
    rd(vec_of(n)[7:0], {tag, " vector low R4"});
    rd(vec_of(n)[15:8], {tag, " vector high R4"});
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(data_out == 8'h00, "R10 data after reset", data_out, 0);
    check(irq_out == 1'b0, "R10 irq after reset", irq_out, 0);

    // R1/R5: two sources together, lowest wins
    pulse_src(8'b0010_1000);
    chk_irq(1'b1, "R1 request latched");
    rd(8'h00, "R7 read without ack");
    set_ack(1'b1); #1;
    check(irq_out == 1'b0, "R2 irq low during ack", irq_out, 0);
    full_call(3, "R5 src3 before src5");
    rd(8'h00, "R11 read past third byte");
    set_ack(1'b0);
    chk_irq(1'b1, "R6 src5 still latched");
    set_ack(1'b1);
    full_call(5, "src5");
    set_ack(1'b0);
    chk_irq(1'b0, "R6 all serviced");

    // R9: early abort, then full retry
    pulse_src(8'h80);
    set_ack(1'b1);
    rd(8'hCD, "R9 opcode before abort");
    set_ack(1'b0);
    chk_irq(1'b1, "R9 request kept after abort");
    set_ack(1'b1);
    full_call(7, "R9 retry src7");
    set_ack(1'b0);
    chk_irq(1'b0, "R6 src7 cleared");

    // R5: choice frozen at ack rise
    pulse_src(8'h40);
    set_ack(1'b1);
    rd(8'hCD, "R5 opcode src6");
    pulse_src(8'h02);
    rd(vec_of(6)[7:0], "R5 frozen low byte");
    rd(vec_of(6)[15:8], "R5 frozen high byte");
    set_ack(1'b0);
    chk_irq(1'b1, "R6 src1 latched after src6");
    set_ack(1'b1);
    full_call(1, "src1");
    set_ack(1'b0);

    // R4: source 0 vector, R8: IO read ignored mid sequence
    pulse_src(8'h01);
    set_ack(1'b1);
    rd(8'h00, "R8 io read during ack", 1'b1);
    rd(8'hCD, "R8 opcode not skipped");
    rd(8'h00, "R8 io read mid call", 1'b1);
    rd(vec_of(0)[7:0], "R4 src0 low");
    rd(vec_of(0)[15:8], "R4 src0 high");
    set_ack(1'b0);
    chk_irq(1'b0, "R6 src0 cleared");

    // R11: acknowledge with nothing pending
    set_ack(1'b1);
    rd(8'h00, "R11 empty ack byte0");
    rd(8'h00, "R11 empty ack byte1");
    set_ack(1'b0);

    // R10: reset mid sequence
    pulse_src(8'h10);
    set_ack(1'b1);
    rd(8'hCD, "R10 opcode before reset");
    @(negedge clk); rst = 1'b1; cpu_ack = 1'b0;
    @(negedge clk); rst = 1'b0;
    chk_irq(1'b0, "R10 requests cleared");
    set_ack(1'b1);
    rd(8'h00, "R10 counter and requests cleared");
    set_ack(1'b0);

    @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule